// File: doc/BRIEF.md
# Pipelined AES-128 Block Encryptor

This block turns 128-bit plaintext blocks into ciphertext under a 128-bit key, one block per clock. The ten cipher rounds and the initial key whitening are unrolled into eleven register stages. A block that enters the first stage leaves the last one eleven cycles later, while up to eleven blocks are in flight at once. The byte substitution is computed in gates: a multiplicative inverse in GF(2^8), then an affine map over GF(2). No stored table is used.

The round keys come in on one flat bus from a key schedule outside the block. The host must hold that bus steady while any block that depends on it is still in the pipeline. Blocks enter on a valid/ready handshake and leave on another. When the consumer holds back the output, the whole pipeline freezes in place and the input side stops accepting blocks. No block is lost, duplicated or reordered. Whenever the output is taken, the input takes a new block in the same cycle.

Top module: `aes128_enc_pipe`

## Requirements
- R1: During reset and after it, `out_valid` is low until a block has been accepted and has travelled the pipeline.
- R2: The ciphertext follows AES-128 with this bus layout. The most significant byte of a 128-bit bus is state byte 0. Byte i sits in row i mod 4, column i div 4. Round key k occupies bits [128k+127:128k] of `round_keys`. Key 000102…0f with plaintext 00112233…ff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: With `out_ready` held high, a block accepted in cycle t appears on the output in cycle t+11, and each stage passes its valid bit to the next on every advancing cycle.
- R4: With `out_ready` high, `in_ready` stays high. Blocks offered on consecutive cycles are all accepted and leave in order, each with its correct ciphertext.
- R5: The substitution maps 0x00 to 0x63. An all-zero key with an all-zero plaintext gives 66e94bd4ef8a2c3b884cfa59ca342b2e.
- R6: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high and `out_data` unchanged.
- R7: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. Stalls lose and duplicate no block.
- R8: Cycles with `in_valid` low travel as bubbles. Each accepted block yields exactly one output handshake, and no output appears without an accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid bits |
| in_valid | input | 1 | Plaintext block offered |
| in_ready | output | 1 | Block accepted when high together with `in_valid` |
| in_data | input | 128 | Plaintext, byte 0 in the top bits |
| round_keys | input | 1408 | Eleven round keys, key k at bits [128k+127:128k] |
| out_valid | output | 1 | Ciphertext present |
| out_ready | input | 1 | Consumer takes the ciphertext |
| out_data | output | 128 | Ciphertext, byte 0 in the top bits |

## Verification
The bench checks three known answers, including the all-zero case. A wrong substitution of zero, a row shift in the wrong direction, or a swapped byte order each change every output byte. It measures the latency of a lone block, so a missing or extra stage shows up as a count other than eleven. It pushes a long unbroken burst and a burst with gaps: a stage that drops or repeats its valid bit leaves a block missing or a spurious output. It also holds the output back in the middle of a stream: a design that keeps accepting, or lets the last stage move, loses a block or changes `out_data` under the stall.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BLK_W  = 128;
  localparam int unsigned NBYTES = BLK_W / BYTE_W;
  localparam int unsigned NCOLS  = 4;
  localparam int unsigned COL_W  = BLK_W / NCOLS;

  typedef logic [BYTE_W-1:0] byte_t;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_xtime(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc = 8'h00;
    byte_t sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // a^254 is the inverse for a != 0 and yields 0 for a == 0
  function automatic byte_t gf_inv(input byte_t a);
    byte_t p2, p3, p12, p15, p240;
    p2   = gf_mul(a, a);
    p3   = gf_mul(p2, a);
    p12  = gf_mul(gf_mul(p3, p3), gf_mul(p3, p3));
    p15  = gf_mul(p12, p3);
    p240 = gf_mul(p15, p15);
    p240 = gf_mul(p240, p240);
    p240 = gf_mul(p240, p240);
    p240 = gf_mul(p240, p240);
    return gf_mul(gf_mul(p240, p12), p2);
  endfunction

  function automatic byte_t affine_fwd(input byte_t b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_enc_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);
  byte_t inv;

  always_comb inv = gf_inv(din);
  always_comb dout = affine_fwd(inv);

  // zero has no inverse and must land on the affine constant
  always_comb begin
    if (din == 8'h00) begin
      p_sbox_zero_r5: assert (dout == 8'h63)
        else $error("R5 substitution of zero is %h", dout);
    end
  end
endmodule

// File: rtl/aes_mixcol.sv
module aes_mixcol
  import aes_enc_pkg::*;
(
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o
);
  byte_t a [NCOLS];
  byte_t d [NCOLS];

  for (genvar r = 0; r < NCOLS; r++) begin : g_row
    assign a[r] = col_i[COL_W-1-BYTE_W*r -: BYTE_W];
    assign d[r] = gf_xtime(a[r]);
    assign col_o[COL_W-1-BYTE_W*r -: BYTE_W] =
      d[r] ^ d[(r+1)%NCOLS] ^ a[(r+1)%NCOLS] ^ a[(r+2)%NCOLS] ^ a[(r+3)%NCOLS];
  end
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_enc_pkg::*;
#(
  parameter bit FINAL = 1'b0
) (
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  output logic [BLK_W-1:0] state_o
);
  byte_t            sub [NBYTES];
  logic [BLK_W-1:0] shf_flat;
  logic [BLK_W-1:0] mix_flat;

  for (genvar i = 0; i < NBYTES; i++) begin : g_sub
    aes_sbox u_sbox (
      .din  (state_i[BLK_W-1-BYTE_W*i -: BYTE_W]),
      .dout (sub[i])
    );
  end

  // row r moves left by r columns
  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    for (genvar r = 0; r < NCOLS; r++) begin : g_row
      assign shf_flat[BLK_W-1-BYTE_W*(c*NCOLS+r) -: BYTE_W] =
        sub[((c+r)%NCOLS)*NCOLS+r];
    end
  end

  if (FINAL) begin : g_nomix
    assign mix_flat = shf_flat;
  end else begin : g_mix
    for (genvar c = 0; c < NCOLS; c++) begin : g_mc
      aes_mixcol u_mix (
        .col_i (shf_flat[BLK_W-1-COL_W*c -: COL_W]),
        .col_o (mix_flat[BLK_W-1-COL_W*c -: COL_W])
      );
    end
  end

  assign state_o = mix_flat ^ rkey_i;
endmodule

// File: rtl/aes128_enc_pipe.sv
module aes128_enc_pipe
  import aes_enc_pkg::*;
#(
  parameter int unsigned ROUNDS = 10,
  localparam int unsigned NKEYS = ROUNDS + 1,
  localparam int unsigned KBUS_W = NKEYS * BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BLK_W-1:0]  in_data,
  input  logic [KBUS_W-1:0] round_keys,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BLK_W-1:0]  out_data
);
  logic [BLK_W-1:0] st_q [0:ROUNDS];
  logic [BLK_W-1:0] nx   [1:ROUNDS];
  logic [ROUNDS:0]  vld_q;
  logic             advance;

  // the whole pipe moves unless the last stage holds an untaken block
  assign advance  = !(vld_q[ROUNDS] && !out_ready);
  assign in_ready = advance;

  for (genvar s = 1; s <= ROUNDS; s++) begin : g_stage
    aes_round #(.FINAL(s == ROUNDS)) u_round (
      .state_i (st_q[s-1]),
      .rkey_i  (round_keys[s*BLK_W +: BLK_W]),
      .state_o (nx[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (advance) vld_q <= {vld_q[ROUNDS-1:0], in_valid};
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      st_q[0] <= in_data ^ round_keys[0 +: BLK_W];
      for (int s = 1; s <= ROUNDS; s++) st_q[s] <= nx[s];
    end
  end

  assign out_valid = vld_q[ROUNDS];
  assign out_data  = st_q[ROUNDS];

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  for (genvar s = 1; s <= ROUNDS; s++) begin : g_chk
    p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[s-1] && in_ready) |=> vld_q[s]);
    p_no_spawn_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!vld_q[s-1] && in_ready) |=> !vld_q[s]);
  end
endmodule

// File: tb/aes128_enc_pipe_tb.sv
module aes128_enc_pipe_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [127:0]  in_data = '0;
  logic [1407:0] rkeys = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [127:0]  out_data;

  aes128_enc_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .round_keys(rkeys), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  logic [7:0] sb [0:255];
  logic [127:0] expq [$];
  logic [127:0] e_cur;
  logic prev_stall = 1'b0;
  logic [127:0] prev_data = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  task automatic build_sbox();
    logic [7:0] p = 8'h01, q = 8'h01, x;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [1407:0] expand(input logic [127:0] key);
    logic [31:0] w [0:43];
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    logic [1407:0] bus;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int k = 0; k < 11; k++)
      bus[k*128 +: 128] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
    return bus;
  endfunction

  function automatic logic [127:0] aes_ref(input logic [127:0] pt);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] rk, res;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rkeys[127-8*i -: 8];
    for (int r = 1; r <= 10; r++) begin
      rk = rkeys[r*128 +: 128];
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) t[c*4+w] = sb[s[((c+w)%4)*4+w]];
      if (r < 10) begin
        for (int c = 0; c < 4; c++) begin
          logic [7:0] a0 = t[c*4], a1 = t[c*4+1], a2 = t[c*4+2], a3 = t[c*4+3];
          t[c*4]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
          t[c*4+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
          t[c*4+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
          t[c*4+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
      end
      for (int i = 0; i < 16; i++) s[i] = t[i] ^ rk[127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  // scoreboard and handshake monitor, sampled mid-cycle
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R6 held output", out_data, prev_data);
      if (out_valid && !out_ready) chk(!in_ready, "R7 ready low in stall", 128'(in_ready), 128'd0);
      else chk(in_ready, "R7 ready high", 128'(in_ready), 128'd1);
      if (in_valid && in_ready) expq.push_back(aes_ref(in_data));
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, "R8 spurious output", out_data, '0);
        else begin
          e_cur = expq.pop_front();
          chk(out_data == e_cur, "R4 stream data", out_data, e_cur);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  task automatic push(input logic [127:0] d);
    @(negedge clk);
    in_valid <= 1'b1;
    in_data  <= d;
    #3;
    while (!in_ready) begin
      @(negedge clk);
      #3;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid <= 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 valid in reset", 128'(out_valid), 128'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      #3;
      chk(!out_valid, "R1 valid after reset", 128'(out_valid), 128'd0);
    end
  endtask

  task automatic run_one(input logic [127:0] key, input logic [127:0] pt,
                         input logic [127:0] exp, input string req);
    longint c0;
    rkeys = expand(key);
    @(negedge clk);
    in_valid <= 1'b1;
    in_data  <= pt;
    c0 = cyc;
    @(negedge clk);
    in_valid <= 1'b0;
    #3;
    for (int k = 0; k < 20; k++) begin
      if (out_valid) break;
      @(negedge clk);
      #3;
    end
    chk(cyc - c0 == 11, "R3 latency", 128'(cyc - c0), 128'd11);
    chk(out_data == exp, req, out_data, exp);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_burst();
    longint c1;
    logic [127:0] v = 128'h0123456789abcdeffedcba9876543210;
    rkeys = expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
    c1 = 0;
    for (int i = 0; i < 20; i++) begin
      push(v);
      if (i == 0) c1 = cyc;
      v = {v[94:0], v[127:95]} ^ 128'(i * 32'h9e3779b9);
    end
    chk(cyc - c1 == 19, "R4 one block per cycle", 128'(cyc - c1), 128'd19);
    idle(15);
    chk(expq.size() == 0, "R4 burst drained", 128'(expq.size()), 128'd0);
  endtask

  task automatic t_bubble();
    rkeys = expand(128'h000102030405060708090a0b0c0d0e0f);
    for (int i = 0; i < 8; i++) begin
      push(128'(i) * 128'h11111111_22222222_33333333_44444444);
      idle(i % 3);
    end
    idle(15);
    #3;
    chk(expq.size() == 0, "R8 one output per input", 128'(expq.size()), 128'd0);
    chk(!out_valid, "R8 no output after drain", 128'(out_valid), 128'd0);
  endtask

  task automatic t_stall();
    rkeys = expand(128'hfffefdfcfbfaf9f8f7f6f5f4f3f2f1f0);
    fork
      begin
        for (int i = 0; i < 16; i++) push({4{32'(i) ^ 32'ha5a5_5a5a}});
        idle(1);
      end
      begin
        repeat (14) @(negedge clk);
        out_ready <= 1'b0;
        repeat (5) @(negedge clk);
        out_ready <= 1'b1;
        repeat (2) @(negedge clk);
        out_ready <= 1'b0;
        @(negedge clk);
        out_ready <= 1'b1;
      end
    join
    repeat (25) @(negedge clk);
    #3;
    chk(expq.size() == 0, "R7 no block lost in stall", 128'(expq.size()), 128'd0);
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    build_sbox();
    t_reset();
    run_one(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2 known answer");
    run_one(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
            128'h3925841d02dc09fbdc118597196a0b32, "R2 second known answer");
    run_one('0, '0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R5 zero block");
    t_burst();
    t_bubble();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule